// File: doc/BRIEF.md
# Integer ALU with Immediate Operand Handling

This block is the combinational integer execution unit of a small load/store processor. Each cycle it takes two register operands, a 16-bit immediate field from the instruction word and a 4-bit operation select. It returns one 32-bit result and an equality flag. It has no clock and no state, so the result is valid in the same cycle that the operands arrive.

The block handles the immediate field itself. Arithmetic and compare operations sign-extend the immediate. Bitwise operations zero-extend it. The upper-load operation places the immediate in the high half of the result and zero-fills the low half. Because of this, an upper-load followed by a bitwise OR with an immediate builds any 32-bit constant.

The equality flag compares the two register operands directly. It is valid for every operation select, so branch logic can use it without choosing a particular operation.

Top module: `exu_alu`

## Requirements
- R1: With op_i = 0, result_o equals opa_i + opb_i, modulo 2^32.
- R2: With op_i = 1, result_o equals opa_i - opb_i, modulo 2^32.
- R3: With op_i = 2, result_o is 1 when opa_i is less than opb_i as signed two's-complement numbers, and 0 otherwise. This includes operands of opposite sign.
- R4: With op_i = 3, result_o equals opa_i plus imm_i sign-extended to 32 bits.
- R5: With op_i = 4, result_o is 1 when opa_i is signed-less-than imm_i sign-extended, and 0 otherwise.
- R6: With op_i = 5, result_o equals opa_i AND imm_i zero-extended, so bits 31:16 of the result are always 0.
- R7: With op_i = 6, result_o equals opa_i OR imm_i zero-extended, so bits 31:16 equal opa_i[31:16].
- R8: With op_i = 7, result_o[31:16] equals imm_i and result_o[15:0] is 0. opa_i and opb_i have no effect on the result.
- R9: If an op_i = 7 result with immediate H is fed back as opa_i to op_i = 6 with immediate L, the result is {H, L}.
- R10: equal_o is 1 exactly when opa_i and opb_i are bit-for-bit identical, whatever the value of op_i.
- R11: Any op_i value from 8 to 15 gives result_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand |
| imm_i | input | 16 | Immediate field of the instruction |
| op_i | input | 4 | Operation select (encoding listed in the requirements) |
| result_o | output | 32 | Operation result |
| equal_o | output | 1 | High when opa_i equals opb_i |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath and a 16-bit immediate. At these widths the signed boundaries of both operands can be hit directly, for example 0x7FFFFFFF against 0x80000000. The immediate's own sign bit (0x8000 against 0x7FFF) can also be hit, which tells sign extension apart from zero extension. Random vectors cover the whole select space, including the undefined codes. They are mixed with directed opposite-sign compares, carries out of bit 31, and the upper-load then OR sequence.

// File: rtl/exu_alu_pkg.sv
package exu_alu_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_SLT  = 4'd2,
    ALU_ADDI = 4'd3,
    ALU_SLTI = 4'd4,
    ALU_ANDI = 4'd5,
    ALU_ORI  = 4'd6,
    ALU_LUI  = 4'd7
  } alu_op_e;

endpackage

// File: rtl/exu_imm_unit.sv
module exu_imm_unit #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm_i,
  output logic [XLEN-1:0]  sext_o,
  output logic [XLEN-1:0]  zext_o,
  output logic [XLEN-1:0]  upper_o
);

  localparam int unsigned FILL_W = XLEN - IMM_W;

  generate
    if (FILL_W > 0) begin : g_widen
      assign sext_o  = {{FILL_W{imm_i[IMM_W-1]}}, imm_i};
      assign zext_o  = {{FILL_W{1'b0}}, imm_i};
      assign upper_o = {imm_i, {FILL_W{1'b0}}};
    end else begin : g_same
      assign sext_o  = imm_i;
      assign zext_o  = imm_i;
      assign upper_o = imm_i;
    end
  endgenerate

  // The upper-load value must keep the immediate in its top bits and zeros below.
  always_comb begin
    a_r8_upper_layout: assert (upper_o[XLEN-1 -: IMM_W] == imm_i)
      else $error("upper immediate misplaced");
    // Sign extension and zero extension differ only when the immediate is negative.
    a_r6_ext_agree: assert ((sext_o == zext_o) || imm_i[IMM_W-1] || (FILL_W == 0))
      else $error("extensions disagree on positive immediate");
  end

endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            lt_o
);

  localparam int unsigned MSB = XLEN - 1;

  logic [XLEN-1:0] b_eff;
  logic            ovf;

  always_comb begin
    b_eff = b_i ^ {XLEN{sub_i}};
    sum_o = a_i + b_eff + {{(XLEN-1){1'b0}}, sub_i};
    ovf   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    lt_o  = sum_o[MSB] ^ ovf;
  end

  always_comb begin
    if (sub_i) begin
      a_r3_lt_signed: assert (lt_o == ($signed(a_i) < $signed(b_i)))
        else $error("signed compare wrong");
    end
  end

endmodule

// File: rtl/exu_logic.sv
module exu_logic #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] m_i,
  output logic [XLEN-1:0] and_o,
  output logic [XLEN-1:0] or_o,
  output logic            eq_o
);

  always_comb begin
    and_o = a_i & m_i;
    or_o  = a_i | m_i;
    eq_o  = ~|(a_i ^ b_i);
  end

  always_comb begin
    a_r10_equal: assert (eq_o == (a_i == b_i))
      else $error("equality flag wrong");
  end

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_alu_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [XLEN-1:0]  opa_i,
  input  logic [XLEN-1:0]  opb_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [XLEN-1:0]  result_o,
  output logic             equal_o
);

  localparam int unsigned LOW_W = XLEN - IMM_W;

  alu_op_e         op;
  logic [XLEN-1:0] imm_sext, imm_zext, imm_upper;
  logic [XLEN-1:0] add_b, sum, and_v, or_v;
  logic            use_imm, do_sub, lt;

  assign op = alu_op_e'(op_i);

  exu_imm_unit #(.XLEN(XLEN), .IMM_W(IMM_W)) u_imm (
    .imm_i   (imm_i),
    .sext_o  (imm_sext),
    .zext_o  (imm_zext),
    .upper_o (imm_upper)
  );

  always_comb begin
    use_imm = (op == ALU_ADDI) || (op == ALU_SLTI);
    do_sub  = (op == ALU_SUB) || (op == ALU_SLT) || (op == ALU_SLTI);
    add_b   = use_imm ? imm_sext : opb_i;
  end

  exu_addsub #(.XLEN(XLEN)) u_addsub (
    .a_i   (opa_i),
    .b_i   (add_b),
    .sub_i (do_sub),
    .sum_o (sum),
    .lt_o  (lt)
  );

  exu_logic #(.XLEN(XLEN)) u_logic (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .m_i   (imm_zext),
    .and_o (and_v),
    .or_o  (or_v),
    .eq_o  (equal_o)
  );

  always_comb begin
    case (op)
      ALU_ADD, ALU_SUB, ALU_ADDI: result_o = sum;
      ALU_SLT, ALU_SLTI:          result_o = {{(XLEN-1){1'b0}}, lt};
      ALU_ANDI:                   result_o = and_v;
      ALU_ORI:                    result_o = or_v;
      ALU_LUI:                    result_o = imm_upper;
      default:                    result_o = '0;
    endcase
  end

  always_comb begin
    if (op == ALU_SLT || op == ALU_SLTI) begin
      a_r3_slt_bool: assert (result_o[XLEN-1:1] == '0)
        else $error("compare result not boolean");
    end
    if (op == ALU_LUI) begin
      a_r8_lui_low_zero: assert (result_o[LOW_W-1:0] == '0)
        else $error("upper load low half not zero");
    end
    if (op == ALU_ANDI) begin
      a_r6_andi_high_zero: assert (result_o[XLEN-1:IMM_W] == '0)
        else $error("and-immediate high half not zero");
    end
    if (op == ALU_ORI) begin
      a_r7_ori_high_kept: assert (result_o[XLEN-1:IMM_W] == opa_i[XLEN-1:IMM_W])
        else $error("or-immediate altered high half");
    end
    if (op_i[OP_W-1]) begin
      a_r11_unknown_zero: assert (result_o == '0)
        else $error("undefined select gave nonzero");
    end
  end

endmodule

// File: tb/exu_alu_test.sv
module exu_alu_test;

  logic        clk = 1'b0;
  logic [31:0] opa, opb;
  logic [15:0] imm;
  logic [3:0]  op;
  logic [31:0] result;
  logic        equal;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  exu_alu uut (
    .opa_i(opa), .opb_i(opb), .imm_i(imm), .op_i(op),
    .result_o(result), .equal_o(equal)
  );

  function automatic logic [31:0] model(input logic [3:0] o, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] i);
    logic [31:0] se, ze;
    se = {{16{i[15]}}, i};
    ze = {16'h0000, i};
    case (o)
      4'd0: return a + b;
      4'd1: return a - b;
      4'd2: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd3: return a + se;
      4'd4: return ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
      4'd5: return a & ze;
      4'd6: return a | ze;
      4'd7: return {i, 16'h0000};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (op %0d a %h b %h imm %h)",
               req, act, exp, op, opa, opb, imm);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] i);
    @(posedge clk);
    #1;
    op = o; opa = a; opb = b; imm = i;
    @(negedge clk);
    check32(req_of(o), result, model(o, a, b, i));
    check32("R10", {31'd0, equal}, {31'd0, a == b});
  endtask

  initial begin
    logic [31:0] hi_word;
    void'($urandom(32'd20240611));
    op = 4'd0; opa = '0; opb = '0; imm = '0;
    @(negedge clk);
    check32("R1", result, 32'd0);           // all-zero start
    check32("R10", {31'd0, equal}, 32'd1);

    apply(4'd0, 32'hFFFF_FFFF, 32'd1, 16'h0);          // R1 wrap
    apply(4'd1, 32'd0, 32'd1, 16'h0);                  // R2 borrow
    apply(4'd2, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0);  // R3 opposite signs -> 1
    apply(4'd2, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0);  // R3 -> 0
    apply(4'd2, 32'h1234_5678, 32'h1234_5678, 16'h0);  // R3 equal -> 0, R10
    apply(4'd2, 32'hFFFF_FFFF, 32'd0, 16'h0);          // R3 -1 < 0
    apply(4'd3, 32'd5, 32'd0, 16'hFFFF);               // R4 add -1
    apply(4'd3, 32'd5, 32'd0, 16'h7FFF);               // R4 positive max
    apply(4'd4, 32'hFFFF_0000, 32'd0, 16'h8000);       // R5 sign-extended imm
    apply(4'd4, 32'd0, 32'd0, 16'h8000);               // R5 0 vs -32768 -> 0
    apply(4'd5, 32'hFFFF_FFFF, 32'd0, 16'h8001);       // R6 zero-extension
    apply(4'd6, 32'hABCD_0000, 32'd0, 16'h8123);       // R7
    apply(4'd7, 32'hDEAD_BEEF, 32'h1234_5678, 16'hCAFE); // R8 operands ignored
    apply(4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF); // R11
    apply(4'd15, 32'h1, 32'h2, 16'h3);                 // R11

    // R9: build a constant with an upper load followed by OR-immediate
    apply(4'd7, 32'h0, 32'h0, 16'h89AB);
    hi_word = result;
    apply(4'd6, hi_word, 32'h0, 16'hCDEF);
    check32("R9", result, 32'h89AB_CDEF);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      logic [3:0]  o;
      o = 4'($urandom_range(0, 15));
      a = $urandom();
      b = ($urandom_range(0, 7) == 0) ? a : $urandom();
      case ($urandom_range(0, 5))
        0: a = 32'h8000_0000;
        1: b = 32'h7FFF_FFFF;
        default: ;
      endcase
      apply(o, a, b, 16'($urandom()));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule